// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Byte-Lane Writes

This block is a synchronous RAM 32 bits wide, built as four 8-bit lanes, with a depth set by a parameter. Each clock edge registers the incoming word address when the chip is selected and awake. Read data comes straight from the array at that registered address, so a read result is valid in the same cycle that follows the edge, with no output register in the path. Writes commit at the edge using the address and write data presented with them.

The write controls have a fixed order of precedence. An active-low global write stores the whole word. Otherwise, an active-low byte-write gate together with four active-low lane enables stores only the lanes that are selected. When none of these applies, the cycle is a read. A burst-start flag from the processor-side strobe blocks all writes for its cycle, so that cycle reads. The data bus is shown as a value plus a drive enable. The enable is asserted only after a read access, while output enable is low and the block is awake. Write, deselect and sleep cycles all leave the bus released.

Top module: `ftsram_top`

## Requirements
- R1: With `gw_ni` low in a selected, awake cycle that is not a burst start, all four lanes of the word at `addr_i` take `wdata_i`, whatever `bwe_ni` and `be_ni` are.
- R2: With `gw_ni` high and `bwe_ni` high, the cycle is a read, and no lane of the array changes, whatever `be_ni` is.
- R3: With `gw_ni` high and `bwe_ni` low, lane k is written exactly when `be_ni[k]` is 0. Lane k covers bits 8k+7:8k, so lane 0 is bits 7:0 and lane 3 is bits 31:24. With `be_ni` = 4'hF the cycle is a read.
- R4: In a cycle with `ps_start_i` high, every write control is ignored, no lane changes, and the cycle acts as a read.
- R5: After a read access edge, `dq_o` equals the stored word at the registered address in that same cycle, and `dq_oe_o` is 1 while `oe_ni` is low and `sleep_i` is low. A change of `oe_ni` shows on `dq_oe_o` without waiting for a clock edge.
- R6: `dq_oe_o` is 0 whenever `oe_ni` is high.
- R7: After a write cycle, `dq_oe_o` stays 0 until a new read access is clocked.
- R8: After a deselected cycle (`sel_i` low), `dq_oe_o` is 0.
- R9: While `sleep_i` is high, `dq_oe_o` is 0, and every other input is ignored: no write happens and the registered address holds.
- R10: When `sleep_i` is released, `dq_oe_o` stays 0 until a new read access is clocked.
- R11: While reset is asserted and after it is released, `dq_oe_o` is 0 until the first read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select, active high |
| sleep_i | input | 1 | Sleep request; assert only while deselected |
| ps_start_i | input | 1 | First cycle of a processor-strobe burst; blocks writes |
| addr_i | input | ADDR_W | Word address from the burst sequencer |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte-write gate, active low |
| be_ni | input | 4 | Lane write enables, active low, bit k for lane k |
| oe_ni | input | 1 | Output enable, active low |
| wdata_i | input | 32 | Write data |
| dq_o | output | 32 | Read data from the registered address |
| dq_oe_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The bench builds the block with `ADDR_W` = 4, a 16-word array. At that size it can write and read back every address, and it can apply all sixteen lane-enable patterns to a single word while a bench-side model tracks the expected contents lane by lane. The small depth also makes it cheap to check that ignored stimuli (reads driven with write data, burst-start cycles, and writes attempted during sleep) left the array unchanged, by reading the words back through the normal read path.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;
  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/ftsram_wr_dec.sv
module ftsram_wr_dec
  import ftsram_pkg::*;
(
  input  logic       access_i,
  input  logic       ps_start_i,
  input  logic       gw_ni,
  input  logic       bwe_ni,
  input  lane_mask_t be_ni,
  output lane_mask_t we_o,
  output logic       rd_o
);
  lane_mask_t lane_req;

  always_comb begin
    if (!gw_ni)       lane_req = '1;
    else if (!bwe_ni) lane_req = ~be_ni;
    else              lane_req = '0;
  end

  // burst-start cycle never writes
  assign we_o = (access_i && !ps_start_i) ? lane_req : '0;
  assign rd_o = access_i && (we_o == '0);
endmodule

// File: rtl/ftsram_array.sv
module ftsram_array
  import ftsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  lane_mask_t        we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/ftsram_bus_ctl.sv
module ftsram_bus_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic sleep_i,
  input  logic oe_ni,
  output logic dq_oe_o
);
  logic rd_active_q;

  // cleared by write, deselect and sleep; set only by a read access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_active_q <= 1'b0;
    else if (sleep_i) rd_active_q <= 1'b0;
    else              rd_active_q <= rd_i;
  end

  assign dq_oe_o = rd_active_q && !oe_ni && !sleep_i;
endmodule

// File: rtl/ftsram_top.sv
module ftsram_top
  import ftsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              sleep_i,
  input  logic              ps_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [3:0]        be_ni,
  input  logic              oe_ni,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       dq_o,
  output logic              dq_oe_o
);
  logic              access;
  lane_mask_t        we;
  logic              rd;
  logic [ADDR_W-1:0] addr_q;

  assign access = sel_i && !sleep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (access) addr_q <= addr_i;
  end

  ftsram_wr_dec u_dec (
    .access_i  (access),
    .ps_start_i(ps_start_i),
    .gw_ni     (gw_ni),
    .bwe_ni    (bwe_ni),
    .be_ni     (be_ni),
    .we_o      (we),
    .rd_o      (rd)
  );

  ftsram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(addr_i),
    .wdata_i(wdata_i),
    .raddr_i(addr_q),
    .rdata_o(dq_o)
  );

  ftsram_bus_ctl u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd),
    .sleep_i(sleep_i),
    .oe_ni  (oe_ni),
    .dq_oe_o(dq_oe_o)
  );
endmodule

// File: rtl/ftsram_chk.sv
module ftsram_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sel_i,
  input logic        sleep_i,
  input logic        ps_start_i,
  input logic        gw_ni,
  input logic        bwe_ni,
  input logic [3:0]  be_ni,
  input logic        oe_ni,
  input logic [31:0] dq_o,
  input logic        dq_oe_o
);
  logic wr_cyc, rd_cyc;
  assign wr_cyc = sel_i && !sleep_i && !ps_start_i && (!gw_ni || (!bwe_ni && be_ni != 4'hF));
  assign rd_cyc = sel_i && !sleep_i && !wr_cyc;

  a_r5_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cyc |=> (oe_ni || sleep_i || dq_oe_o));
  a_r6_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);
  a_r7_write_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cyc |=> !dq_oe_o);
  a_r8_desel_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !dq_oe_o);
  a_r9_sleep_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);
  a_r9_sleep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(dq_o));
  a_r10_wake_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !dq_oe_o);
endmodule

bind ftsram_top ftsram_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .sleep_i   (sleep_i),
  .ps_start_i(ps_start_i),
  .gw_ni     (gw_ni),
  .bwe_ni    (bwe_ni),
  .be_ni     (be_ni),
  .oe_ni     (oe_ni),
  .dq_o      (dq_o),
  .dq_oe_o   (dq_oe_o)
);

// File: tb/ftsram_top_tb.sv
module ftsram_top_tb;
  localparam int unsigned AW = 4;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_i = 1'b0, sleep_i = 1'b0, ps_start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          gw_ni = 1'b1, bwe_ni = 1'b1, oe_ni = 1'b0;
  logic [3:0]    be_ni = 4'hF;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   dq_o;
  logic          dq_oe_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model [DEPTH];

  always #5 clk_i = ~clk_i;

  ftsram_top #(.ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .sleep_i(sleep_i),
    .ps_start_i(ps_start_i), .addr_i(addr_i), .gw_ni(gw_ni), .bwe_ni(bwe_ni),
    .be_ni(be_ni), .oe_ni(oe_ni), .wdata_i(wdata_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle();
    sel_i = 1'b0; ps_start_i = 1'b0; gw_ni = 1'b1; bwe_ni = 1'b1; be_ni = 4'hF;
  endtask

  task automatic rd_word(input logic [AW-1:0] a, input string req);
    idle(); sel_i = 1'b1; addr_i = a; wdata_i = ~model[a];
    step();
    chk(req, {31'd0, dq_oe_o}, 32'd1);
    chk(req, dq_o, model[a]);
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] ben);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (!ben[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 2000; i++) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    chk("R11 reset", {31'd0, dq_oe_o}, 32'd0);
    step();
    rst_ni = 1'b1;
    step();
    chk("R11 after reset", {31'd0, dq_oe_o}, 32'd0);

    // R1: global write over every address, other write controls varied
    for (int a = 0; a < DEPTH; a++) begin
      idle(); sel_i = 1'b1; gw_ni = 1'b0; bwe_ni = a[0]; be_ni = a[3:0];
      addr_i = AW'(a); wdata_i = 32'h1357_0000 + 32'(a) * 32'h0101_0111;
      model[a] = wdata_i;
      step();
      chk("R7 hiz after write", {31'd0, dq_oe_o}, 32'd0);
    end
    for (int a = 0; a < DEPTH; a++) rd_word(AW'(a), "R1 readback");

    // R3: every lane-enable pattern on one word
    for (int m = 0; m < 16; m++) begin
      idle(); sel_i = 1'b1; bwe_ni = 1'b0; be_ni = 4'(m);
      addr_i = 4'd5; wdata_i = {4{8'(8'hA0 + m)}};
      model[5] = merge(model[5], wdata_i, 4'(m));
      step();
      chk("R3 drive", {31'd0, dq_oe_o}, (m == 15) ? 32'd1 : 32'd0);
      if (m == 15) chk("R3 all-high is read", dq_o, model[5]);
      rd_word(4'd5, "R3 lane merge");
    end

    // R2: byte-write gate high blocks writes
    idle(); sel_i = 1'b1; bwe_ni = 1'b1; be_ni = 4'h0; addr_i = 4'd9; wdata_i = 32'hDEAD_BEEF;
    step();
    chk("R2 read drive", {31'd0, dq_oe_o}, 32'd1);
    chk("R2 read data", dq_o, model[9]);
    rd_word(4'd9, "R2 unchanged");

    // R4: burst-start cycle ignores global write
    idle(); sel_i = 1'b1; ps_start_i = 1'b1; gw_ni = 1'b0; addr_i = 4'd12; wdata_i = 32'hCAFE_F00D;
    step();
    chk("R4 acts as read", {31'd0, dq_oe_o}, 32'd1);
    chk("R4 data", dq_o, model[12]);
    idle(); sel_i = 1'b1; ps_start_i = 1'b1; bwe_ni = 1'b0; be_ni = 4'h0; addr_i = 4'd12;
    step();
    rd_word(4'd12, "R4 unchanged");

    // R5/R6: output enable is combinational
    oe_ni = 1'b1;
    idle(); sel_i = 1'b1; addr_i = 4'd3;
    step();
    chk("R6 oe high", {31'd0, dq_oe_o}, 32'd0);
    oe_ni = 1'b0; #1;
    chk("R5 oe low same cycle", {31'd0, dq_oe_o}, 32'd1);
    chk("R5 flow-through data", dq_o, model[3]);

    // R8: deselect releases bus
    idle();
    step();
    chk("R8 deselect hiz", {31'd0, dq_oe_o}, 32'd0);

    // R9/R10: sleep
    rd_word(4'd7, "R5 before sleep");
    idle(); sleep_i = 1'b1; #1;
    chk("R9 sleep hiz", {31'd0, dq_oe_o}, 32'd0);
    sel_i = 1'b1; gw_ni = 1'b0; addr_i = 4'd3; wdata_i = 32'h0BAD_0BAD;
    step();
    chk("R9 sleep hiz clocked", {31'd0, dq_oe_o}, 32'd0);
    chk("R9 address held", dq_o, model[7]);
    idle(); sleep_i = 1'b0; #1;
    chk("R10 wake hiz", {31'd0, dq_oe_o}, 32'd0);
    step();
    chk("R10 hiz until read", {31'd0, dq_oe_o}, 32'd0);
    rd_word(4'd3, "R9 sleep write ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule